// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Clock Gating

This block decides which clocks and analog sources of a small system-on-chip run. Software writes a 3-bit power-down code into a one-field control register. While the chip is in its normal running state, the block picks up that code and moves to one of four low-power modes. Each deeper mode turns off a strict superset of what the shallower one turns off. Going from shallow to deep, the modes switch off the CPU and watchdog clocks, then the peripheral clocks, then the PLL, and last the main oscillator. The slow 32.768 kHz oscillator always stays on.

An interrupt, sampled as a level, brings the chip back to the running state in a fixed order. From the deepest mode the block first restarts the main oscillator and waits a programmable settling count. It then enables the PLL and waits for lock. Only after lock does it open the clock gates. After any reset the block holds system reset low until the PLL locks and for eight more cycles after that.

The block runs on an always-on clock. Its states are: RST_LOCK (wait for lock), RST_HOLD (stretch reset), ACTIVE, STANDBY, SLEEP, STOP1, STOP2, WAKE_OSC (oscillator settling) and WAKE_PLL (wait for lock). The transitions are:
- RST_LOCK goes to RST_HOLD when lock is seen.
- RST_HOLD goes to ACTIVE after eight cycles.
- ACTIVE goes to STANDBY, SLEEP, STOP1 or STOP2 on codes 001, 010, 011 or 100.
- STANDBY and SLEEP go to ACTIVE on an interrupt.
- STOP1 goes to WAKE_PLL on an interrupt.
- STOP2 goes to WAKE_OSC on an interrupt.
- WAKE_OSC goes to WAKE_PLL when the settling count expires.
- WAKE_PLL goes to ACTIVE when lock is seen.

Top module: `pwr_mode_seq`

## Requirements
- R1: While rst_n is low: sys_rst_n=0, mode_status=3'b111, sel_field=0, the CPU, watchdog and peripheral clock enables are 0, and pll_en, main_osc_en and slow_osc_en are 1.
- R2: After rst_n rises, sys_rst_n stays 0 and the clock enables stay off until pll_lock is sampled high. From the next edge the clock enables are all 1, mode_status stays 3'b111, and sys_rst_n stays 0 for exactly 8 cycles. Then mode_status=3'b000 and sys_rst_n=1.
- R3: Code 001 moves ACTIVE to Standby. mode_status=3'b001, the CPU and watchdog enables are 0, and all others are 1. Outputs change on the second edge after the write is sampled.
- R4: Code 010 moves ACTIVE to Sleep. mode_status=3'b010, all three clock enables are 0, and the PLL and both oscillators are on.
- R5: Code 011 moves ACTIVE to Stop1. mode_status=3'b011, all clocks are off, the PLL is off, and both oscillators are on.
- R6: Code 100 moves ACTIVE to Stop2. mode_status=3'b100, and only slow_osc_en is 1.
- R7: A write in ACTIVE is visible on sel_field for one cycle, then the field reads 3'b000. Codes 101, 110 and 111 leave the block in ACTIVE. Writes made outside ACTIVE are ignored. Writes made while a code is still pending are also ignored.
- R8: In Standby or Sleep, irq_any high returns the block to ACTIVE on the edge that samples it, with all enables at 1.
- R9: In Stop1, irq_any moves the block to waking (mode_status=3'b101) with pll_en=1 and the clocks off. The block enters ACTIVE on the edge that samples pll_lock high.
- R10: In Stop2, irq_any starts waking with main_osc_en=1 and pll_en=0 for max(osc_wait_cfg,1) cycles. The block then proceeds as in R9.
- R11: The enables are always nested: per implies pll, pll implies main oscillator, and main oscillator implies slow oscillator. The CPU and watchdog enables are always equal.
- R12: irq_any has no effect in ACTIVE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-on block clock |
| rst_n | input | 1 | async active-low combined reset (external, watchdog, soft) |
| sel_wr | input | 1 | write strobe for the power-down code field |
| sel_wdata | input | 3 | power-down code being written |
| irq_any | input | 1 | OR of all interrupts, level, synchronous to clk |
| pll_lock | input | 1 | PLL lock indication |
| osc_wait_cfg | input | OSC_CNT_W | main oscillator settling cycles |
| sel_field | output | 3 | current content of the code field |
| mode_status | output | 3 | current mode code |
| sys_rst_n | output | 1 | stretched system reset, active low |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| wdt_clk_en | output | 1 | watchdog clock gate enable |
| per_clk_en | output | 1 | peripheral clock gate enable |
| pll_en | output | 1 | PLL enable |
| main_osc_en | output | 1 | main oscillator enable |
| slow_osc_en | output | 1 | 32.768 kHz oscillator enable |

## Verification
A code written at one edge shows on sel_field after that edge. It clears after the next edge, and the mode outputs move at that same next edge, two edges after the write. An interrupt in Standby or Sleep restores ACTIVE one edge after it is sampled. A wake from Stop1 lasts one cycle longer than the bench PLL model's lock latency, and a wake from Stop2 adds max(osc_wait_cfg,1) cycles of oscillator settling in front of that. The bench drives and samples on falling edges and counts waking cycles one by one against these formulas. The reset stretch is likewise counted as exactly eight cycles after lock.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [3:0] {
        S_RST_LOCK,
        S_RST_HOLD,
        S_ACTIVE,
        S_STANDBY,
        S_SLEEP,
        S_STOP1,
        S_STOP2,
        S_WAKE_OSC,
        S_WAKE_PLL
    } pwr_state_e;

    localparam logic [2:0] CODE_STANDBY = 3'b001;
    localparam logic [2:0] CODE_SLEEP   = 3'b010;
    localparam logic [2:0] CODE_STOP1   = 3'b011;
    localparam logic [2:0] CODE_STOP2   = 3'b100;

    localparam logic [2:0] STAT_ACTIVE  = 3'b000;
    localparam logic [2:0] STAT_WAKING  = 3'b101;
    localparam logic [2:0] STAT_RESET   = 3'b111;

    typedef struct packed {
        logic cpu;
        logic wdt;
        logic per;
        logic pll;
        logic mosc;
        logic sosc;
    } gate_t;

endpackage

// File: rtl/pwr_cycle_count.sv
module pwr_cycle_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwr_gate_decode.sv
module pwr_gate_decode
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e state_nxt,
    output gate_t      gates,
    output logic [2:0] status,
    output logic       sys_rst_n
);

    gate_t      gates_d;
    logic [2:0] status_d;
    logic       srst_d;

    always_comb begin
        gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
        status_d = STAT_RESET;
        srst_d   = 1'b0;
        unique case (state_nxt)
            S_RST_LOCK: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
                status_d = STAT_RESET;
                srst_d   = 1'b0;
            end
            S_RST_HOLD: begin
                gates_d  = '{cpu: 1'b1, wdt: 1'b1, per: 1'b1, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
                status_d = STAT_RESET;
                srst_d   = 1'b0;
            end
            S_ACTIVE: begin
                gates_d  = '{cpu: 1'b1, wdt: 1'b1, per: 1'b1, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
                status_d = STAT_ACTIVE;
                srst_d   = 1'b1;
            end
            S_STANDBY: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b1, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
                status_d = CODE_STANDBY;
                srst_d   = 1'b1;
            end
            S_SLEEP: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
                status_d = CODE_SLEEP;
                srst_d   = 1'b1;
            end
            S_STOP1: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b0, mosc: 1'b1, sosc: 1'b1};
                status_d = CODE_STOP1;
                srst_d   = 1'b1;
            end
            S_STOP2: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b0, mosc: 1'b0, sosc: 1'b1};
                status_d = CODE_STOP2;
                srst_d   = 1'b1;
            end
            S_WAKE_OSC: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b0, mosc: 1'b1, sosc: 1'b1};
                status_d = STAT_WAKING;
                srst_d   = 1'b1;
            end
            S_WAKE_PLL: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
                status_d = STAT_WAKING;
                srst_d   = 1'b1;
            end
            default: begin
                gates_d  = '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
                status_d = STAT_RESET;
                srst_d   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gates     <= '{cpu: 1'b0, wdt: 1'b0, per: 1'b0, pll: 1'b1, mosc: 1'b1, sosc: 1'b1};
            status    <= STAT_RESET;
            sys_rst_n <= 1'b0;
        end else begin
            gates     <= gates_d;
            status    <= status_d;
            sys_rst_n <= srst_d;
        end
    end

    // R11: enable nesting across every registered output set
    p_gate_nest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!gates.per || gates.pll) && (!gates.pll || gates.mosc) && (!gates.mosc || gates.sosc));

    // R11: CPU and watchdog gates move together
    p_cpu_wdt_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
        gates.cpu == gates.wdt);

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int HOLD_CYCLES = 8,
    parameter int OSC_CNT_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_wr,
    input  logic [2:0]           sel_wdata,
    input  logic                 irq_any,
    input  logic                 pll_lock,
    input  logic [OSC_CNT_W-1:0] osc_wait_cfg,
    output logic [2:0]           sel_field,
    output logic [2:0]           mode_status,
    output logic                 sys_rst_n,
    output logic                 cpu_clk_en,
    output logic                 wdt_clk_en,
    output logic                 per_clk_en,
    output logic                 pll_en,
    output logic                 main_osc_en,
    output logic                 slow_osc_en
);

    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

    pwr_state_e          state, state_nxt;
    logic [HW-1:0]       hold_cnt;
    logic [OSC_CNT_W-1:0] osc_cnt;
    logic [OSC_CNT_W:0]  osc_inc;
    logic                hold_done, osc_done;
    gate_t               gates;

    pwr_cycle_count #(.W(HW)) u_hold_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != S_RST_HOLD),
        .en   (1'b1),
        .cnt  (hold_cnt)
    );

    pwr_cycle_count #(.W(OSC_CNT_W)) u_osc_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != S_WAKE_OSC),
        .en   (1'b1),
        .cnt  (osc_cnt)
    );

    assign hold_done = (hold_cnt == HOLD_LAST);
    assign osc_inc   = {1'b0, osc_cnt} + 1'b1;
    assign osc_done  = (osc_inc >= {1'b0, osc_wait_cfg});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_RST_LOCK;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_field <= 3'b000;
        end else if (state == S_ACTIVE) begin
            if (sel_field != 3'b000) begin
                sel_field <= 3'b000;
            end else if (sel_wr) begin
                sel_field <= sel_wdata;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_RST_LOCK: if (pll_lock) state_nxt = S_RST_HOLD;
            S_RST_HOLD: if (hold_done) state_nxt = S_ACTIVE;
            S_ACTIVE: begin
                unique case (sel_field)
                    CODE_STANDBY: state_nxt = S_STANDBY;
                    CODE_SLEEP:   state_nxt = S_SLEEP;
                    CODE_STOP1:   state_nxt = S_STOP1;
                    CODE_STOP2:   state_nxt = S_STOP2;
                    default:      state_nxt = S_ACTIVE;
                endcase
            end
            S_STANDBY:  if (irq_any) state_nxt = S_ACTIVE;
            S_SLEEP:    if (irq_any) state_nxt = S_ACTIVE;
            S_STOP1:    if (irq_any) state_nxt = S_WAKE_PLL;
            S_STOP2:    if (irq_any) state_nxt = S_WAKE_OSC;
            S_WAKE_OSC: if (osc_done) state_nxt = S_WAKE_PLL;
            S_WAKE_PLL: if (pll_lock) state_nxt = S_ACTIVE;
            default:    state_nxt = S_RST_LOCK;
        endcase
    end

    pwr_gate_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_nxt(state_nxt),
        .gates    (gates),
        .status   (mode_status),
        .sys_rst_n(sys_rst_n)
    );

    assign cpu_clk_en  = gates.cpu;
    assign wdt_clk_en  = gates.wdt;
    assign per_clk_en  = gates.per;
    assign pll_en      = gates.pll;
    assign main_osc_en = gates.mosc;
    assign slow_osc_en = gates.sosc;

    // R2: reset releases only after the full stretch counted
    p_stretch_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> ($past(hold_cnt) == HOLD_LAST));

    // R7: a pending code is consumed after one cycle
    p_field_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACTIVE && sel_field != 3'b000) |=> (sel_field == 3'b000));

    // R7: reserved codes keep the block running
    p_noop_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACTIVE && sel_field >= 3'd5) |=> (mode_status == STAT_ACTIVE));

    // R9: no peripheral clock before lock while waking
    p_wait_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAKE_PLL && !pll_lock) |=> !per_clk_en);

    // R10: oscillator settles with the PLL still off
    p_osc_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAKE_OSC) |-> (!pll_en && main_osc_en));

    // R12: interrupt alone does not disturb the running state
    p_active_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ACTIVE && irq_any && sel_field == 3'b000) |=> (mode_status == STAT_ACTIVE));

endmodule

// File: tb/pwr_mode_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb_top;

    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = 3'b000;
    logic       irq_any = 1'b0;
    logic       pll_lock = 1'b0;
    logic [7:0] osc_wait_cfg = 8'd3;
    logic [2:0] sel_field, mode_status;
    logic       sys_rst_n, cpu_clk_en, wdt_clk_en, per_clk_en;
    logic       pll_en, main_osc_en, slow_osc_en;
    logic [2:0] lock_cnt = 3'd0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_seq dut_i (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .irq_any(irq_any), .pll_lock(pll_lock), .osc_wait_cfg(osc_wait_cfg),
        .sel_field(sel_field), .mode_status(mode_status), .sys_rst_n(sys_rst_n),
        .cpu_clk_en(cpu_clk_en), .wdt_clk_en(wdt_clk_en), .per_clk_en(per_clk_en),
        .pll_en(pll_en), .main_osc_en(main_osc_en), .slow_osc_en(slow_osc_en)
    );

    // PLL model: lock after LAT enabled edges, drops one edge after disable
    always @(posedge clk) begin
        if (!rst_n || !pll_en) begin
            lock_cnt <= 3'd0;
            pll_lock <= 1'b0;
        end else if (lock_cnt == 3'(LAT - 1)) begin
            pll_lock <= 1'b1;
        end else begin
            lock_cnt <= lock_cnt + 1'b1;
        end
    end

    function automatic logic [5:0] gates_now();
        return {cpu_clk_en, wdt_clk_en, per_clk_en, pll_en, main_osc_en, slow_osc_en};
    endfunction

    function automatic logic [5:0] exp_gate(input logic [2:0] st);
        case (st)
            3'b000:  return 6'b111111;
            3'b001:  return 6'b001111;
            3'b010:  return 6'b000111;
            3'b011:  return 6'b000011;
            3'b100:  return 6'b000001;
            default: return 6'b000111;
        endcase
    endfunction

    function automatic logic [2:0] exp_mode(input logic [2:0] code);
        return (code >= 3'd1 && code <= 3'd4) ? code : 3'b000;
    endfunction

    function automatic int exp_wake(input logic [2:0] code, input int cfg);
        if (code == 3'd3) return LAT + 1;
        if (code == 3'd4) return ((cfg < 1) ? 1 : cfg) + LAT + 1;
        return 0;
    endfunction

    function automatic string req_of(input logic [2:0] code);
        case (code)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic enter(input logic [2:0] code);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = code;
        @(negedge clk);
        sel_wr = 1'b0;
        chk(sel_field == code, "R7", "field after write", sel_field, code);
        @(negedge clk);
        chk(sel_field == 3'b000, "R7", "field cleared", sel_field, 0);
        chk(mode_status == exp_mode(code), req_of(code), "mode status", mode_status, exp_mode(code));
        chk(gates_now() == exp_gate(exp_mode(code)), req_of(code), "gates in mode",
            gates_now(), exp_gate(exp_mode(code)));
    endtask

    task automatic wake(input logic [2:0] code, input int cfg);
        int n;
        int osc_len;
        osc_len = (cfg < 1) ? 1 : cfg;
        irq_any = 1'b1;
        @(negedge clk);
        n = 0;
        while (mode_status == 3'b101 && n < 200) begin
            chk(per_clk_en == 1'b0, "R9", "clock off while waking", per_clk_en, 0);
            if (code == 3'd4 && n < osc_len)
                chk(pll_en == 1'b0 && main_osc_en == 1'b1, "R10", "osc before pll",
                    {pll_en, main_osc_en}, 1);
            n++;
            @(negedge clk);
        end
        chk(n == exp_wake(code, cfg), (code == 3'd4) ? "R10" : "R9", "waking cycles", n, exp_wake(code, cfg));
        chk(mode_status == 3'b000, "R8", "back to active", mode_status, 0);
        chk(gates_now() == 6'b111111, "R8", "all gates on", gates_now(), 6'b111111);
        irq_any = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        int hold;
        logic [2:0] code;
        int cfg;
        int dly;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        chk(mode_status == 3'b111 && sys_rst_n == 1'b0, "R1", "reset status", mode_status, 7);
        chk(gates_now() == 6'b000111, "R1", "reset gates", gates_now(), 6'b000111);
        chk(sel_field == 3'b000, "R1", "reset field", sel_field, 0);

        rst_n = 1'b1;
        n = 0;
        while (mode_status == 3'b111 && per_clk_en == 1'b0 && n < 50) begin
            n++;
            @(negedge clk);
        end
        chk(n == LAT + 1, "R2", "cycles before lock", n, LAT + 1);
        hold = 0;
        while (mode_status == 3'b111 && per_clk_en == 1'b1 && hold < 50) begin
            chk(sys_rst_n == 1'b0, "R2", "reset held in stretch", sys_rst_n, 0);
            hold++;
            @(negedge clk);
        end
        chk(hold == 8, "R2", "stretch length", hold, 8);
        chk(mode_status == 3'b000 && sys_rst_n == 1'b1, "R2", "active after stretch", mode_status, 0);

        // R12: interrupt while running
        irq_any = 1'b1;
        repeat (3) @(negedge clk);
        chk(mode_status == 3'b000 && gates_now() == 6'b111111, "R12", "irq in active", mode_status, 0);
        irq_any = 1'b0;

        // R7: reserved codes
        enter(3'd5);
        enter(3'd7);

        // R7: writes outside ACTIVE are dropped
        enter(3'd1);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = 3'd2;
        @(negedge clk);
        sel_wr = 1'b0;
        @(negedge clk);
        chk(sel_field == 3'b000, "R7", "write in standby ignored", sel_field, 0);
        chk(mode_status == 3'b001, "R7", "standby kept", mode_status, 1);
        wake(3'd1, 0);

        // R10 corner cases of the settling count
        osc_wait_cfg = 8'd0;
        enter(3'd4);
        repeat (2) @(negedge clk);
        wake(3'd4, 0);
        osc_wait_cfg = 8'd5;
        enter(3'd4);
        repeat (2) @(negedge clk);
        wake(3'd4, 5);

        // random mix
        for (int i = 0; i < 40; i++) begin
            code = 3'($urandom_range(0, 7));
            cfg = $urandom_range(0, 6);
            dly = $urandom_range(1, 5);
            osc_wait_cfg = 8'(cfg);
            enter(code);
            if (exp_mode(code) != 3'b000) begin
                repeat (dly) @(negedge clk);
                chk(mode_status == code, req_of(code), "mode held", mode_status, code);
                wake(code, cfg);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule